// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to 32 interrupt pins that come from outside the chip. Each pin passes through its own synchronizer. Its programmed sense mode then decides whether the pin counts as an event. The modes are low level, high level, falling edge, rising edge or either edge. An event is latched in a per-pin detect flag. When that flag is set and the pin is enabled, the pin raises its own output line toward a downstream interrupt controller. The pins never share an output line.

Software reaches the block through one 32-bit register interface. Enabling and disabling use separate write-one registers, so no read-modify-write is needed. Detect flags are cleared by writing ones. Every pin has a 32-bit configuration word whose six low bits select the sense mode. Each pin channel holds a two-state latch machine. In DET_IDLE, an event takes the transition "latch" to DET_PENDING. In DET_PENDING, a write-one clear with no event in the same cycle takes the transition "clear" back to DET_IDLE. A clear that arrives together with an event leaves the machine in DET_PENDING.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, every pin is disabled and every `irq_out` bit is low.
- R2: Level sense modes use code 0x01 for active low and 0x02 for active high. A pin change is visible in the detect status, and on `irq_out` when the pin is enabled, on the third rising clock edge after the change, and not earlier.
- R3: Edge sense modes use code 0x04 for falling, 0x08 for rising and 0x0C for either edge. An opposite-direction transition does not latch.
- R4: A sense field of 0x00 or any code not listed in R2 and R3 never latches a detection.
- R5: Detect status sits at offset 0x100. Bit n reads 1 while pin n is latched. Writing 1 to a bit clears that bit, and writing 0 has no effect. An event in the same cycle as the clear wins.
- R6: In a level mode the detect flag latches again on every cycle the level stays active, so a clear takes effect only once the pin is inactive.
- R7: Writing 1 to bit n at offset 0x008 enables pin n, and writing 1 at offset 0x004 disables it. Zero bits change nothing. Both offsets read back the enable mask.
- R8: Offset 0x000 reads the detect status ANDed with the enable mask, and `irq_out[n]` equals bit n of that value.
- R9: Pin n owns a 32-bit read/write configuration word at offset 0x180 + 4*n. Bits [5:0] of that word are the sense mode, and writing one word leaves every other word unchanged.
- R10: Reads from unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; edges are detected on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Raw external interrupt pins |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_out | output | NUM_PINS | One interrupt line per pin |

## Verification
A pin channel whose latch machine sits in the wrong state shows up on its own `irq_out` bit and in its detect-status bit by the next clock edge. A faulty sense decode or synchronizer instead moves the rising edge of that bit away from the third clock edge after the pin change, so the bench samples on both sides of that edge. Enable and clear faults are caught by register reads issued straight after the write, because each register takes effect at the very next edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;

    // register offsets inside the single CPU bank
    localparam logic [ADDR_W-1:0] OFS_REQ     = 9'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 9'h004;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 9'h008;
    localparam logic [ADDR_W-1:0] OFS_DET     = 9'h100;
    localparam logic [1:0]        CFG_REGION  = 2'b11;   // addr[8:7] for 0x180..0x1FC

    // sense field codes
    localparam logic [5:0] SENSE_LOW  = 6'h01;
    localparam logic [5:0] SENSE_HIGH = 6'h02;
    localparam logic [5:0] SENSE_FALL = 6'h04;
    localparam logic [5:0] SENSE_RISE = 6'h08;
    localparam logic [5:0] SENSE_BOTH = 6'h0C;

    typedef struct packed {
        logic lvl_lo;
        logic lvl_hi;
        logic fall;
        logic rise;
        logic valid;
    } sense_mode_t;

    typedef enum logic {
        DET_IDLE,
        DET_PENDING
    } det_state_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_REQ,
        REG_EN_CLR,
        REG_EN_SET,
        REG_DET,
        REG_CFG
    } reg_region_t;

    function automatic sense_mode_t sense_decode(input logic [5:0] code);
        sense_mode_t m;
        m = '0;
        unique case (code)
            SENSE_LOW:  m.lvl_lo = 1'b1;
            SENSE_HIGH: m.lvl_hi = 1'b1;
            SENSE_FALL: m.fall   = 1'b1;
            SENSE_RISE: m.rise   = 1'b1;
            SENSE_BOTH: begin
                m.fall = 1'b1;
                m.rise = 1'b1;
            end
            default: m = '0;
        endcase
        m.valid = m.lvl_lo | m.lvl_hi | m.fall | m.rise;
        return m;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic lvl_prev_o
);

    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], pin_i};
        end
    end

    assign lvl_o      = chain_q[STAGES-1];
    assign lvl_prev_o = chain_q[STAGES];

endmodule

// File: rtl/irq_pin_channel.sv
module irq_pin_channel
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic              lvl_prev_i,
    input  logic              cfg_we_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              det_clr_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    output logic [DATA_W-1:0] cfg_o,
    output logic              det_o,
    output logic              en_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] cfg_q;
    logic              en_q;
    det_state_t        state_q, state_d;
    sense_mode_t       mode;
    logic              hit;

    // configuration word, whole width is storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we_i) begin
            cfg_q <= cfg_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_set_i) begin
            en_q <= 1'b1;
        end else if (en_clr_i) begin
            en_q <= 1'b0;
        end
    end

    always_comb begin
        mode = sense_decode(cfg_q[5:0]);
        hit  = (mode.lvl_lo & ~lvl_i)
             | (mode.lvl_hi &  lvl_i)
             | (mode.fall   &  lvl_prev_i & ~lvl_i)
             | (mode.rise   & ~lvl_prev_i &  lvl_i);
    end

    // latch machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_IDLE: begin
                if (hit) state_d = DET_PENDING;              // latch
            end
            DET_PENDING: begin
                if (det_clr_i && !hit) state_d = DET_IDLE;   // clear
            end
            default: state_d = DET_IDLE;
        endcase
    end

    // latch machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // latch machine: outputs
    always_comb begin
        det_o = (state_q == DET_PENDING);
        en_o  = en_q;
        irq_o = det_o & en_q;
        cfg_o = cfg_q;
    end

    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.rise && lvl_i && !lvl_prev_i) |=> det_o);                  // R3
    AST_FALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.fall && !lvl_i && lvl_prev_i) |=> det_o);                  // R3
    AST_LEVEL_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.lvl_hi && lvl_i) |=> det_o);                               // R6
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.valid && !det_o) |=> !det_o);                             // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_clr_i && !mode.valid) |=> !det_o);                          // R5
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_i |=> en_o);                                              // R7
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr_i && !en_set_i) |=> !en_o);                              // R7

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sel_i,
    input  logic                              we_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    input  logic [NUM_PINS-1:0]               en_i,
    input  logic [NUM_PINS-1:0]               det_i,
    input  logic [NUM_PINS-1:0][DATA_W-1:0]   cfg_i,
    output logic [NUM_PINS-1:0]               en_set_o,
    output logic [NUM_PINS-1:0]               en_clr_o,
    output logic [NUM_PINS-1:0]               det_clr_o,
    output logic [NUM_PINS-1:0]               cfg_we_o,
    output logic [DATA_W-1:0]                 rdata_o
);

    localparam int IDX_W = 5;

    reg_region_t       region;
    logic [IDX_W-1:0]  cfg_idx;
    logic              wr;
    logic [DATA_W-1:0] req_w, en_w, det_w;

    always_comb begin
        cfg_idx = addr_i[6:2];
        region  = REG_NONE;
        if (addr_i == OFS_REQ)         region = REG_REQ;
        else if (addr_i == OFS_EN_CLR) region = REG_EN_CLR;
        else if (addr_i == OFS_EN_SET) region = REG_EN_SET;
        else if (addr_i == OFS_DET)    region = REG_DET;
        else if (addr_i[8:7] == CFG_REGION && addr_i[1:0] == 2'b00
                 && int'(cfg_idx) < NUM_PINS)
            region = REG_CFG;
    end

    assign wr = sel_i & we_i;

    always_comb begin
        en_set_o  = (wr && region == REG_EN_SET) ? wdata_i[NUM_PINS-1:0] : '0;
        en_clr_o  = (wr && region == REG_EN_CLR) ? wdata_i[NUM_PINS-1:0] : '0;
        det_clr_o = (wr && region == REG_DET)    ? wdata_i[NUM_PINS-1:0] : '0;
    end

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_cfg_we
        assign cfg_we_o[k] = wr && (region == REG_CFG) && (cfg_idx == IDX_W'(k));
    end

    always_comb begin
        req_w = '0;
        en_w  = '0;
        det_w = '0;
        req_w[NUM_PINS-1:0] = det_i & en_i;
        en_w[NUM_PINS-1:0]  = en_i;
        det_w[NUM_PINS-1:0] = det_i;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !we_i) begin
            unique case (region)
                REG_REQ:    rdata_o = req_w;
                REG_EN_CLR: rdata_o = en_w;
                REG_EN_SET: rdata_o = en_w;
                REG_DET:    rdata_o = det_w;
                REG_CFG:    rdata_o = cfg_i[cfg_idx];
                default:    rdata_o = '0;
            endcase
        end
    end

    AST_ONE_CFG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we_o));                                             // R9
    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_NONE) |-> (en_set_o == '0 && en_clr_o == '0
                                  && det_clr_o == '0 && cfg_we_o == '0)); // R10

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [8:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_out
);

    logic [NUM_PINS-1:0]             lvl, lvl_prev;
    logic [NUM_PINS-1:0]             en_set, en_clr, det_clr, cfg_we;
    logic [NUM_PINS-1:0]             det, en;
    logic [NUM_PINS-1:0][DATA_W-1:0] cfg;

    irq_bus_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .en_i      (en),
        .det_i     (det),
        .cfg_i     (cfg),
        .en_set_o  (en_set),
        .en_clr_o  (en_clr),
        .det_clr_o (det_clr),
        .cfg_we_o  (cfg_we),
        .rdata_o   (bus_rdata)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (pin_in[n]),
            .lvl_o      (lvl[n]),
            .lvl_prev_o (lvl_prev[n])
        );

        irq_pin_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .lvl_i       (lvl[n]),
            .lvl_prev_i  (lvl_prev[n]),
            .cfg_we_i    (cfg_we[n]),
            .cfg_wdata_i (bus_wdata),
            .det_clr_i   (det_clr[n]),
            .en_set_i    (en_set[n]),
            .en_clr_i    (en_clr[n]),
            .cfg_o       (cfg[n]),
            .det_o       (det[n]),
            .en_o        (en[n]),
            .irq_o       (irq_out[n])
        );
    end

    AST_IRQ_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~det) == '0));                                       // R8
    AST_IRQ_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_set & det) != '0) |=> ((irq_out & $past(en_set & det)) != '0)); // R8

endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 32;
    localparam int NVEC       = 13;

    // {sense[5:0], start level, end level, expected latch}
    localparam logic [8:0] VEC [NVEC] = '{
        {6'h01, 1'b1, 1'b0, 1'b1},   // R2 low level active
        {6'h01, 1'b1, 1'b1, 1'b0},   // R2 low level idle
        {6'h02, 1'b0, 1'b1, 1'b1},   // R2 high level active
        {6'h02, 1'b0, 1'b0, 1'b0},   // R2 high level idle
        {6'h04, 1'b1, 1'b0, 1'b1},   // R3 falling
        {6'h04, 1'b0, 1'b1, 1'b0},   // R3 rise ignored in falling mode
        {6'h08, 1'b0, 1'b1, 1'b1},   // R3 rising
        {6'h08, 1'b1, 1'b0, 1'b0},   // R3 fall ignored in rising mode
        {6'h0C, 1'b0, 1'b1, 1'b1},   // R3 both, rising
        {6'h0C, 1'b1, 1'b0, 1'b1},   // R3 both, falling
        {6'h00, 1'b0, 1'b1, 1'b0},   // R4 zero code
        {6'h03, 1'b0, 1'b1, 1'b0},   // R4 invalid code
        {6'h10, 1'b1, 1'b0, 1'b0}    // R4 invalid code
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPINS-1:0]  pin_in = '0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [8:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPINS-1:0]  irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_en = '0;
    logic [31:0] rd;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rdreg(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdreg(9'h000, rd); check("R1 request", rd, 32'h0);
        rdreg(9'h004, rd); check("R1 enable", rd, 32'h0);
        rdreg(9'h008, rd); check("R1 enable set view", rd, 32'h0);
        rdreg(9'h100, rd); check("R1 detect", rd, 32'h0);
        rdreg(9'h180, rd); check("R1 config0", rd, 32'h0);
        check("R1 irq_out", irq_out, 32'h0);

        // table walk: one pin per vector
        for (int i = 0; i < NVEC; i++) begin
            wr(9'h180 + 9'(4*i), {26'h0, VEC[i][8:3]});
            @(negedge clk) pin_in[i] = VEC[i][2];
            repeat (5) @(negedge clk);
            wr(9'h100, 32'h1 << i);
            wr(9'h008, 32'h1 << i);
            exp_en[i] = 1'b1;
            @(negedge clk) pin_in[i] = VEC[i][1];
            repeat (5) @(negedge clk);
            rdreg(9'h000, rd);
            check($sformatf("R8 table row %0d request bit", i), 32'(rd[i]), 32'(VEC[i][0]));
            check($sformatf("R2/R3/R4 table row %0d irq_out", i), 32'(irq_out[i]), 32'(VEC[i][0]));
        end
        rdreg(9'h004, rd); check("R7 enable mask after table", rd, exp_en);

        // R2 latency: high level on pin 20
        wr(9'h180 + 9'(4*20), 32'h02);
        wr(9'h008, 32'h1 << 20); exp_en[20] = 1'b1;
        @(negedge clk) pin_in[20] = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 not latched after two edges", 32'(irq_out[20]), 32'h0);
        @(negedge clk);
        check("R2 latched on third edge", 32'(irq_out[20]), 32'h1);

        // R6 clear while level active does not stick
        wr(9'h100, 32'h1 << 20);
        rdreg(9'h100, rd); check("R6 relatch while active", 32'(rd[20]), 32'h1);
        @(negedge clk) pin_in[20] = 1'b0;
        repeat (4) @(negedge clk);
        wr(9'h100, 32'h1 << 20);
        rdreg(9'h100, rd); check("R6 clear after inactive", 32'(rd[20]), 32'h0);

        // R7/R8/R5 masking on pin 21, rising edge
        wr(9'h180 + 9'(4*21), 32'h08);
        @(negedge clk) pin_in[21] = 1'b1;
        repeat (4) @(negedge clk);
        rdreg(9'h100, rd); check("R5 detect latched while disabled", 32'(rd[21]), 32'h1);
        rdreg(9'h000, rd); check("R8 request masked", 32'(rd[21]), 32'h0);
        check("R8 irq_out masked", 32'(irq_out[21]), 32'h0);
        wr(9'h008, 32'h0);
        rdreg(9'h008, rd); check("R7 zero write to set", rd, exp_en);
        wr(9'h004, 32'h0);
        rdreg(9'h004, rd); check("R7 zero write to clear", rd, exp_en);
        wr(9'h008, 32'h1 << 21); exp_en[21] = 1'b1;
        check("R8 irq_out after enable", 32'(irq_out[21]), 32'h1);
        wr(9'h004, 32'h1 << 21); exp_en[21] = 1'b0;
        check("R7 irq_out after disable", 32'(irq_out[21]), 32'h0);
        rdreg(9'h004, rd); check("R7 enable mask after disable", rd, exp_en);
        wr(9'h100, 32'h0);
        rdreg(9'h100, rd); check("R5 zero write keeps detect", 32'(rd[21]), 32'h1);
        wr(9'h100, 32'h1 << 21);
        rdreg(9'h100, rd); check("R5 edge detect cleared", 32'(rd[21]), 32'h0);

        // R9 configuration storage
        wr(9'h180 + 9'(4*22), 32'hA5A5_5A00);
        rdreg(9'h180 + 9'(4*22), rd); check("R9 config readback", rd, 32'hA5A5_5A00);
        rdreg(9'h180 + 9'(4*23), rd); check("R9 neighbour untouched", rd, 32'h0);
        rdreg(9'h180 + 9'(4*6), rd); check("R9 earlier word kept", rd, 32'h08);

        // R10 unmapped offsets
        wr(9'h010, 32'hFFFF_FFFF);
        wr(9'h104, 32'hFFFF_FFFF);
        wr(9'h182, 32'hFFFF_FFFF);
        rdreg(9'h010, rd); check("R10 bank1 reads zero", rd, 32'h0);
        rdreg(9'h104, rd); check("R10 gap reads zero", rd, 32'h0);
        rdreg(9'h004, rd); check("R10 enable unchanged", rd, exp_en);
        rdreg(9'h180, rd); check("R10 config0 unchanged", rd, 32'h01);

        finish_run();
    end

endmodule